// File: doc/BRIEF.md
# Cyclic Block Read Sequencer

This block decides which memory bit a transponder sends next while it is transmitting. In regular read mode it walks the 32 data bits of each block. It starts at block 1 and runs up to a programmable last block, then wraps back to block 1. A separate single-block mode repeats one selected block without end, for example after a write or a direct-access command.

Each time transmission is (re)started, the block first sends one logical-0 bit period. An optional synchronization terminator can follow. The terminator lasts four bit periods, all carrying data 1, and a gap marker is raised in the second and fourth period. In regular read mode the terminator appears once at the start of every cycle. In single-block mode, and when the last-block value is 0 or 1, it appears before every block.

The sequencer drives a block address and a bit index to the memory. It takes back the addressed bit and passes it to the line encoder, together with flags that say whether the period carries data, terminator or the leading zero. State moves only on the bit-clock strobe.

Top module: `blk_read_seq`

## Requirements
- R1: After reset, and on the cycle after `restart` is sampled high, the block is in the leading period: `tx_bit`=0, `data_vld`=0, `term_flag`=0. This period lasts exactly one bit period (one strobe).
- R2: With `single_mode`=0 and `last_blk`>=2, data runs block 1 bit index 0..31, then blocks 2, 3 and so on up to `last_blk`, then wraps to block 1. Bit index 0 is the first bit sent from a block.
- R3: With `single_mode`=0, `last_blk`=1 repeats block 1 only and `last_blk`=0 repeats block 0. Block 0 is never addressed during data when `last_blk`!=0.
- R4: With `single_mode`=1, only block `single_addr` is sent, repeatedly, whatever `last_blk` is.
- R5: A terminator lasts 4 bit periods with `term_flag`=1, `tx_bit`=1 and `data_vld`=0. `term_gap`=1 in its 2nd and 4th periods only.
- R6: With `term_en`=1 in regular read mode (`last_blk`>=2), a terminator is sent after the leading period and again each time the stream wraps to block 1. None is sent between the other blocks.
- R7: With `term_en`=1 and either `single_mode`=1 or `last_blk`<=1, a terminator precedes every transmission of the repeated block.
- R8: Outputs and state change only on a cycle where `bit_stb` (or `restart`) is high. Without a strobe they hold.
- R9: While `data_vld`=1, `tx_bit` equals `mem_rd_bit`, the memory bit at `blk_addr`/`bit_idx`.
- R10: With `term_en`=0, no terminator is ever sent, and the first data bit follows the leading period directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous restart to the leading-zero period |
| bit_stb | input | 1 | One-cycle strobe marking the end of a bit period |
| last_blk | input | 3 | Last block of a regular cycle |
| term_en | input | 1 | Enables the synchronization terminator |
| single_mode | input | 1 | Repeat a single selected block |
| single_addr | input | 3 | Block repeated in single-block mode |
| mem_rd_bit | input | 1 | Memory bit at the current address and index |
| blk_addr | output | 3 | Block address to memory |
| bit_idx | output | 5 | Bit index within the block, 0 = first sent |
| tx_bit | output | 1 | Serial bit to the encoder |
| data_vld | output | 1 | Current period carries a memory bit |
| term_flag | output | 1 | Current period is part of the terminator |
| term_gap | output | 1 | Terminator period with modulation gap |

## Verification
Every output is a register or a direct decode of one. So the value for a bit period is valid from the clock after the strobe (or restart) that starts it, until the next strobe edge. The bench compares each bit period's outputs at the falling edge of the cycles between strobes, never at the edge that moves the state. It checks every such cycle, so stretched periods with extra idle cycles also test R8. Expected periods come from a sequence model built from the mode inputs before each run. Mode inputs change only while `restart` is high.

// File: rtl/blk_read_seq_pkg.sv
package blk_read_seq_pkg;
    typedef enum logic [1:0] {
        PH_LEAD = 2'd0,
        PH_TERM = 2'd1,
        PH_DATA = 2'd2
    } phase_e;
endpackage

// File: rtl/blk_read_seq_start.sv
module blk_read_seq_start #(
    parameter int AW = 3
) (
    input  logic          single_mode,
    input  logic [AW-1:0] single_addr,
    input  logic [AW-1:0] last_blk,
    output logic [AW-1:0] start_blk,
    output logic          one_blk
);
    always_comb begin
        if (single_mode) begin
            start_blk = single_addr;
            one_blk   = 1'b1;
        end else if (last_blk == '0) begin
            start_blk = '0;
            one_blk   = 1'b1;
        end else begin
            start_blk = AW'(1);
            one_blk   = (last_blk == AW'(1));
        end
    end
endmodule

// File: rtl/blk_read_seq_step.sv
module blk_read_seq_step #(
    parameter int AW = 3
) (
    input  logic [AW-1:0] cur_blk,
    input  logic [AW-1:0] last_blk,
    input  logic [AW-1:0] start_blk,
    input  logic          one_blk,
    output logic [AW-1:0] nxt_blk,
    output logic          wrap
);
    always_comb begin
        if (one_blk || cur_blk >= last_blk) begin
            nxt_blk = start_blk;
            wrap    = 1'b1;
        end else begin
            nxt_blk = cur_blk + AW'(1);
            wrap    = 1'b0;
        end
    end
endmodule

// File: rtl/blk_read_seq.sv
module blk_read_seq
    import blk_read_seq_pkg::*;
#(
    parameter int AW       = 3,
    parameter int BITS     = 32,
    parameter int TERM_LEN = 4,
    parameter int IW       = $clog2(BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          bit_stb,
    input  logic [AW-1:0] last_blk,
    input  logic          term_en,
    input  logic          single_mode,
    input  logic [AW-1:0] single_addr,
    input  logic          mem_rd_bit,
    output logic [AW-1:0] blk_addr,
    output logic [IW-1:0] bit_idx,
    output logic          tx_bit,
    output logic          data_vld,
    output logic          term_flag,
    output logic          term_gap
);
    localparam int TW = (TERM_LEN > 1) ? $clog2(TERM_LEN) : 1;

    typedef struct packed {
        phase_e        phase;
        logic [AW-1:0] blk;
        logic [IW-1:0] bidx;
        logic [TW-1:0] tcnt;
    } seq_t;

    seq_t s_q, s_d;

    logic [AW-1:0] start_blk, nxt_blk;
    logic          one_blk, wrap;

    blk_read_seq_start #(.AW(AW)) u_start (
        .single_mode (single_mode),
        .single_addr (single_addr),
        .last_blk    (last_blk),
        .start_blk   (start_blk),
        .one_blk     (one_blk)
    );

    blk_read_seq_step #(.AW(AW)) u_step (
        .cur_blk   (s_q.blk),
        .last_blk  (last_blk),
        .start_blk (start_blk),
        .one_blk   (one_blk),
        .nxt_blk   (nxt_blk),
        .wrap      (wrap)
    );

    always_comb begin
        s_d = s_q;
        if (restart) begin
            s_d.phase = PH_LEAD;
            s_d.blk   = start_blk;
            s_d.bidx  = '0;
            s_d.tcnt  = '0;
        end else if (bit_stb) begin
            unique case (s_q.phase)
                PH_LEAD: begin
                    s_d.blk   = start_blk;
                    s_d.bidx  = '0;
                    s_d.tcnt  = '0;
                    s_d.phase = term_en ? PH_TERM : PH_DATA;
                end
                PH_TERM: begin
                    if (s_q.tcnt == TW'(TERM_LEN - 1)) begin
                        s_d.phase = PH_DATA;
                        s_d.bidx  = '0;
                    end else begin
                        s_d.tcnt = s_q.tcnt + TW'(1);
                    end
                end
                PH_DATA: begin
                    if (s_q.bidx == IW'(BITS - 1)) begin
                        s_d.bidx = '0;
                        s_d.blk  = nxt_blk;
                        s_d.tcnt = '0;
                        if (wrap && term_en) s_d.phase = PH_TERM;
                    end else begin
                        s_d.bidx = s_q.bidx + IW'(1);
                    end
                end
                default: s_d.phase = PH_LEAD;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_LEAD, blk: '0, bidx: '0, tcnt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign blk_addr  = s_q.blk;
    assign bit_idx   = s_q.bidx;
    assign data_vld  = (s_q.phase == PH_DATA);
    assign term_flag = (s_q.phase == PH_TERM);
    assign term_gap  = term_flag && s_q.tcnt[0];
    assign tx_bit    = data_vld ? mem_rd_bit : term_flag;
endmodule

// File: rtl/blk_read_seq_chk.sv
module blk_read_seq_chk #(
    parameter int AW = 3,
    parameter int IW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          restart,
    input logic          bit_stb,
    input logic [AW-1:0] last_blk,
    input logic          single_mode,
    input logic [AW-1:0] single_addr,
    input logic [AW-1:0] blk_addr,
    input logic [IW-1:0] bit_idx,
    input logic          tx_bit,
    input logic          data_vld,
    input logic          term_flag,
    input logic          term_gap
);
    a_r1_lead_after_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!tx_bit && !data_vld && !term_flag));

    a_r8_hold_without_stb: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_stb && !restart) |=> ($stable(blk_addr) && $stable(bit_idx) &&
                                    $stable(term_flag) && $stable(data_vld)));

    a_r5_term_sends_one: assert property (@(posedge clk) disable iff (!rst_n)
        term_flag |-> (tx_bit && !data_vld));

    a_r5_gap_in_term: assert property (@(posedge clk) disable iff (!rst_n)
        term_gap |-> term_flag);

    a_r3_no_blk0: assert property (@(posedge clk) disable iff (!rst_n || restart)
        (data_vld && !single_mode && last_blk != '0) |-> (blk_addr != '0));

    a_r2_within_last: assert property (@(posedge clk) disable iff (!rst_n || restart)
        (data_vld && !single_mode) |-> (blk_addr <= last_blk));

    a_r4_single_addr: assert property (@(posedge clk) disable iff (!rst_n || restart)
        (data_vld && single_mode) |-> (blk_addr == single_addr));
endmodule

bind blk_read_seq blk_read_seq_chk #(.AW(AW), .IW(IW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .restart     (restart),
    .bit_stb     (bit_stb),
    .last_blk    (last_blk),
    .single_mode (single_mode),
    .single_addr (single_addr),
    .blk_addr    (blk_addr),
    .bit_idx     (bit_idx),
    .tx_bit      (tx_bit),
    .data_vld    (data_vld),
    .term_flag   (term_flag),
    .term_gap    (term_gap)
);

// File: tb/tb_blk_read_seq.sv
module tb_blk_read_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       restart = 1'b0;
    logic       bit_stb = 1'b0;
    logic [2:0] last_blk = 3'd7;
    logic       term_en = 1'b0;
    logic       single_mode = 1'b0;
    logic [2:0] single_addr = 3'd0;
    logic       mem_rd_bit;
    logic [2:0] blk_addr;
    logic [4:0] bit_idx;
    logic       tx_bit, data_vld, term_flag, term_gap;

    int checks = 0;
    int failures = 0;
    logic smp = 1'b0;
    logic done = 1'b0;

    typedef struct {
        logic       tx;
        logic       term;
        logic       gap;
        logic       dv;
        logic [2:0] addr;
        logic [4:0] idx;
        string      tag;
    } exp_t;

    exp_t q[$];

    always #5 clk = ~clk;

    function automatic logic mem_fn(logic [2:0] b, logic [4:0] i);
        int v;
        v = (int'(b) + 1) * (int'(i) + 3);
        return v[1] ^ v[3];
    endfunction

    assign mem_rd_bit = mem_fn(blk_addr, bit_idx);

    blk_read_seq dut (
        .clk (clk), .rst_n (rst_n), .restart (restart), .bit_stb (bit_stb),
        .last_blk (last_blk), .term_en (term_en), .single_mode (single_mode),
        .single_addr (single_addr), .mem_rd_bit (mem_rd_bit),
        .blk_addr (blk_addr), .bit_idx (bit_idx), .tx_bit (tx_bit),
        .data_vld (data_vld), .term_flag (term_flag), .term_gap (term_gap)
    );

    task automatic push(logic tx, logic tm, logic gp, logic dv,
                        logic [2:0] a, logic [4:0] i, string tag);
        exp_t e;
        e.tx = tx; e.term = tm; e.gap = gp; e.dv = dv;
        e.addr = a; e.idx = i; e.tag = tag;
        q.push_back(e);
    endtask

    // Expected stream built from the requirements
    task automatic build(int n);
        int    nblk;
        int    blks[8];
        string ttag, dtag;
        logic  first;
        q.delete();
        push(1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 5'd0, "R1");
        if (single_mode) begin
            nblk = 1; blks[0] = single_addr; dtag = "R4"; ttag = "R7";
        end else if (last_blk <= 3'd1) begin
            nblk = 1; blks[0] = last_blk; dtag = "R3"; ttag = "R7";
        end else begin
            nblk = last_blk;
            for (int k = 0; k < nblk; k++) blks[k] = k + 1;
            dtag = "R2"; ttag = "R6";
        end
        first = 1'b1;
        while (q.size() < n) begin
            if (term_en)
                for (int k = 0; k < 4; k++)
                    push(1'b1, 1'b1, logic'(k % 2), 1'b0, 3'd0, 5'd0,
                         (k == 0) ? "R5" : ttag);
            for (int b = 0; b < nblk; b++)
                for (int i = 0; i < 32; i++) begin
                    push(mem_fn(3'(blks[b]), 5'(i)), 1'b0, 1'b0, 1'b1,
                         3'(blks[b]), 5'(i),
                         (first && !term_en) ? "R10" : ((i % 5 == 0) ? "R9" : dtag));
                    first = 1'b0;
                end
        end
    endtask

    // Monitor: compares every sampled cycle against the head of the queue
    always @(negedge clk) begin
        if (smp && q.size() > 0) begin
            exp_t e;
            logic ok;
            e = q[0];
            ok = (tx_bit === e.tx) && (term_flag === e.term) &&
                 (term_gap === e.gap) && (data_vld === e.dv);
            if (e.dv) ok = ok && (blk_addr === e.addr) && (bit_idx === e.idx);
            checks++;
            if (!ok) begin
                failures++;
                $display("FAIL %s act tx=%b term=%b gap=%b dv=%b blk=%0d idx=%0d exp tx=%b term=%b gap=%b dv=%b blk=%0d idx=%0d",
                         e.tag, tx_bit, term_flag, term_gap, data_vld, blk_addr, bit_idx,
                         e.tx, e.term, e.gap, e.dv, e.addr, e.idx);
            end
        end
    end

    // Driver: mode change under restart, then n bit periods; idle>0 stretches periods (R8)
    task automatic run(logic [2:0] lb, logic te, logic sm, logic [2:0] sa, int n, int idle);
        @(posedge clk); #1;
        last_blk = lb; term_en = te; single_mode = sm; single_addr = sa;
        restart = 1'b1;
        build(n);
        @(posedge clk); #1;
        restart = 1'b0;
        for (int p = 0; p < n; p++) begin
            smp = 1'b1;
            repeat (1 + idle) @(posedge clk);
            #1;
            smp = 1'b0;
            bit_stb = 1'b1;
            @(posedge clk); #1;
            bit_stb = 1'b0;
            q.delete(0);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (tx_bit !== 1'b0 || data_vld !== 1'b0 || term_flag !== 1'b0) begin
            failures++;
            $display("FAIL R1 reset act tx=%b dv=%b term=%b exp 0 0 0", tx_bit, data_vld, term_flag);
        end
        run(3'd3, 1'b0, 1'b0, 3'd0, 140, 0);   // R2 wrap, R10
        run(3'd2, 1'b1, 1'b0, 3'd0, 140, 0);   // R5, R6
        run(3'd1, 1'b1, 1'b0, 3'd0, 80,  0);   // R3, R7
        run(3'd0, 1'b0, 1'b0, 3'd0, 70,  1);   // R3 block 0, R8 idle
        run(3'd7, 1'b1, 1'b1, 3'd5, 80,  2);   // R4, R7, R8
        run(3'd7, 1'b1, 1'b0, 3'd0, 270, 0);   // R2 full cycle, R6 wrap
        run(3'd4, 1'b0, 1'b0, 3'd0, 20,  0);   // restart mid-stream, R1
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule